// File: doc/BRIEF.md
# Lane Load Request Coalescer

This block takes one batch of load requests from sixteen parallel lanes and turns it into the fewest aligned memory transactions it can. Each lane supplies a byte address and an active flag. All lanes in a batch share one access width of 4, 8 or 16 bytes. The block does not issue the memory accesses itself. Its output is the plan for those accesses, one transaction per valid/ready handshake. Each transaction carries a base address, a segment size of 32, 64 or 128 bytes, and the mask of lanes it serves.

The block works in rounds. Each round starts from the lowest-numbered lane that has not yet been served, called the leader. It takes the 128-byte aligned segment that holds the leader's address. It collects every unserved active lane whose address lies in that segment, in any order and at any offset. It then halves the segment for as long as every collected byte span still fits in one aligned half. Lanes that are served leave the pending set. When the pending set is empty, the block returns to idle and pulses `done` for one cycle.

A lane's address does not have to be aligned to the access width. However, a lane's byte span (address through address plus width minus one) must stay inside its own 128-byte segment.

Top module: `req_coalescer`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `done` is 0.
- R2: Lanes whose `in_active` bit is clear never appear in any `out_mask`. A batch with no active lanes produces no transaction and raises `done` in the cycle after it is accepted.
- R3: `out_size` encodes 0 = 32 bytes, 1 = 64 bytes and 2 = 128 bytes, and `out_base` is always a multiple of the size it reports.
- R4: Every active lane is served by exactly one transaction. A transaction serves every still-unserved active lane in the leader's 128-byte segment, whatever the lane order or offset.
- R5: Each transaction includes the lowest-numbered lane still unserved, so transactions leave in order of their leader lane.
- R6: The reported segment is the smallest aligned 32, 64 or 128-byte segment, inside the leader's 128-byte segment, that covers the byte spans of all lanes it serves.
- R7: Sixteen active lanes reading 4 bytes each at consecutive addresses from a 64-byte-aligned base produce exactly one 64-byte transaction with all lanes in its mask.
- R8: The same contiguous 4-byte pattern, starting off a 64-byte boundary and crossing a 128-byte boundary, produces two transactions. For example, a start at offset 116 gives 32 bytes at offset 96, then 64 bytes at the next 128-byte segment.
- R9: `in_size` encodes 0 = 4 bytes, 1 = 8 bytes, and 2 or 3 = 16 bytes. A lane's byte span for the cover check runs from its address to its address plus the width minus one.
- R10: A batch is accepted only while `in_ready` is 1, which holds exactly when no transaction is pending. `in_valid` while busy has no effect on the transactions produced.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_base`, `out_size` and `out_mask` do not change and `out_valid` stays 1.
- R12: `done` pulses for one cycle, in the cycle right after the handshake that serves the last pending lane. No transaction is offered while `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A batch is presented |
| in_ready | output | 1 | Block is idle and takes a batch |
| in_active | input | LANES | Per-lane request enable |
| in_addr | input | LANES*AW | Per-lane byte address, lane i at bits i*AW upward |
| in_size | input | 2 | Shared access width code |
| out_valid | output | 1 | A transaction is offered |
| out_ready | input | 1 | Consumer takes the offered transaction |
| out_base | output | AW | Aligned segment base address |
| out_size | output | 2 | Segment size code |
| out_mask | output | LANES | Lanes served by this transaction |
| done | output | 1 | One-cycle pulse when the batch is finished |

## Verification
The bench builds the block with the default 16 lanes and 32-bit addresses. At that width every lane count and every segment case in the requirements can be reached: all sixteen lanes in one segment, lanes split across two 128-byte segments, and a lone lane at the far end of a mask. Scripted batches cover the contiguous, straddling, permuted, sparse, empty and wider-access cases. Random batches are drawn over a few neighbouring 128-byte segments, which makes multi-round batches common. These run while the consumer stalls at random, so the holding rule and the ordering of rounds are exercised under back-pressure.

// File: rtl/req_coalescer.sv
module req_coalescer #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [LANES-1:0]      in_active,
  input  logic [LANES*AW-1:0]   in_addr,
  input  logic [1:0]            in_size,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [AW-1:0]         out_base,
  output logic [1:0]            out_size,
  output logic [LANES-1:0]      out_mask,
  output logic                  done
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int OW = 7;

  logic              busy;
  logic [LANES-1:0]  pend;
  logic [1:0]        sz_q;
  logic [AW-1:0]     addr_q [LANES];
  logic [LW-1:0]     lead;
  logic [AW-OW-1:0]  seg;
  logic [OW-1:0]     span_m1, lo, hi, s_off, e_off;
  logic              fit64, fit32;

  wire accept = in_valid && !busy;
  wire fire   = out_valid && out_ready;
  wire [LANES-1:0] left = pend & ~out_mask;

  assign in_ready  = !busy;
  assign out_valid = busy;

  assign span_m1 = (sz_q == 2'd0) ? 7'd3 : (sz_q == 2'd1) ? 7'd7 : 7'd15;

  always_comb begin
    lead = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (pend[i]) lead = LW'(i);
  end

  assign seg = addr_q[lead][AW-1:OW];

  always_comb begin
    out_mask = '0;
    lo       = '1;
    hi       = '0;
    s_off    = '0;
    e_off    = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pend[i] && addr_q[i][AW-1:OW] == seg) begin
        out_mask[i] = 1'b1;
        s_off = addr_q[i][OW-1:0];
        e_off = s_off + span_m1;
        if (s_off < lo) lo = s_off;
        if (e_off > hi) hi = e_off;
      end
    end
  end

  assign fit64    = lo[6] == hi[6];
  assign fit32    = fit64 && (lo[5] == hi[5]);
  assign out_size = fit32 ? 2'd0 : fit64 ? 2'd1 : 2'd2;
  assign out_base = {seg, fit64 ? lo[6] : 1'b0, fit32 ? lo[5] : 1'b0, 5'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pend <= '0;
      sz_q <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        sz_q <= in_size;
        pend <= in_active;
        busy <= |in_active;
        done <= ~|in_active;
      end else if (fire) begin
        pend <= left;
        if (left == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept)
      for (int i = 0; i < LANES; i++)
        addr_q[i] <= in_addr[i*AW +: AW];
  end
endmodule

// File: rtl/coalescer_chk.sv
module coalescer_chk #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [AW-1:0]    out_base,
  input logic [1:0]       out_size,
  input logic [LANES-1:0] out_mask,
  input logic             done,
  input logic [LANES-1:0] pend
);
  wire [LANES-1:0] lowbit = pend & (~pend + LANES'(1));

  // R3
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_size != 2'd3) &&
      ((out_size == 2'd0) ? (out_base[4:0] == 5'd0) :
       (out_size == 2'd1) ? (out_base[5:0] == 6'd0) : (out_base[6:0] == 7'd0)));

  // R4
  mask_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask != '0) && ((out_mask & ~pend) == '0));

  // R4
  served_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> ((pend & $past(out_mask)) == '0));

  // R5
  leader_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_mask & lowbit) != '0));

  // R10
  idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_base) &&
      $stable(out_size) && $stable(out_mask));

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid && (pend == '0));
endmodule

bind req_coalescer coalescer_chk #(.LANES(LANES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_base(out_base), .out_size(out_size),
  .out_mask(out_mask), .done(done), .pend(pend)
);

// File: tb/test_req_coalescer.sv
module test_req_coalescer;
  localparam int LANES = 16;
  localparam int AW    = 32;
  localparam int IW    = AW + 2 + LANES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LANES-1:0] in_active = '0;
  logic [LANES*AW-1:0] in_addr = '0;
  logic [1:0] in_size = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [AW-1:0] out_base;
  logic [1:0] out_size;
  logic [LANES-1:0] out_mask;
  logic done;

  always #2 clk = ~clk;

  req_coalescer #(.LANES(LANES), .AW(AW)) i_req_coalescer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_active(in_active), .in_addr(in_addr), .in_size(in_size),
    .out_valid(out_valid), .out_ready(out_ready), .out_base(out_base),
    .out_size(out_size), .out_mask(out_mask), .done(done)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int last_hs = 0;
  int txn_cnt = 0;
  int ready_mode = 1;
  logic [AW-1:0] last_base;
  logic [1:0] last_size;
  logic [IW-1:0] expq[$];

  logic [LANES-1:0] b_act;
  logic [AW-1:0] b_addr [LANES];
  logic [1:0] b_sz;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ready_mode == 0) out_ready <= 1'b0;
    else if (ready_mode == 1) out_ready <= 1'b1;
    else out_ready <= 1'($urandom % 2);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model();
    logic [LANES-1:0] p, m;
    int bm1, lo, hi, ld, o;
    logic [AW-1:0] sb;
    logic [1:0] sc;
    p = b_act;
    bm1 = (b_sz == 0) ? 3 : (b_sz == 1) ? 7 : 15;
    while (p != 0) begin
      ld = 0;
      for (int i = LANES - 1; i >= 0; i--) if (p[i]) ld = i;
      m = '0; lo = 127; hi = 0;
      for (int i = 0; i < LANES; i++)
        if (p[i] && (b_addr[i] >> 7) == (b_addr[ld] >> 7)) begin
          m[i] = 1'b1;
          o = int'(b_addr[i] & 32'h7f);
          if (o < lo) lo = o;
          if (o + bm1 > hi) hi = o + bm1;
        end
      sb = (b_addr[ld] >> 7) << 7;
      if (lo / 32 == hi / 32) begin sc = 2'd0; sb = sb + AW'((lo / 32) * 32); end
      else if (lo / 64 == hi / 64) begin sc = 2'd1; sb = sb + AW'((lo / 64) * 64); end
      else sc = 2'd2;
      expq.push_back({sb, sc, m});
      p = p & ~m;
    end
  endtask

  logic hold_pend = 1'b0;
  logic [IW-1:0] hold_val;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        check(out_valid == 1'b1, "R11", "valid dropped while stalled", 64'(out_valid), 64'd1);
        check({out_base, out_size, out_mask} == hold_val, "R11", "fields moved while stalled",
              64'({out_base, out_size, out_mask}), 64'(hold_val));
      end
      hold_pend = out_valid && !out_ready;
      hold_val  = {out_base, out_size, out_mask};
      if (out_valid && out_ready) begin
        if (expq.size() == 0)
          check(1'b0, "R4", "unexpected transaction", 64'({out_base, out_size, out_mask}), 64'd0);
        else begin
          logic [IW-1:0] e;
          e = expq.pop_front();
          check({out_base, out_size, out_mask} == e, "R6", "transaction base/size/mask",
                64'({out_base, out_size, out_mask}), 64'(e));
        end
        txn_cnt++;
        last_hs = cyc + 1;
        last_base = out_base;
        last_size = out_size;
      end
    end
  end

  task automatic run_batch(input bit intrude);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    txn_cnt = 0;
    in_valid = 1'b1;
    in_active = b_act;
    in_size = b_sz;
    for (int i = 0; i < LANES; i++) in_addr[i*AW +: AW] = b_addr[i];
    model();
    if (intrude) ready_mode = 0;
    @(negedge clk);
    in_valid = 1'b0;
    if (b_act == '0) begin
      check(done == 1'b1, "R2", "empty batch done", 64'(done), 64'd1);
      check(out_valid == 1'b0, "R2", "empty batch offers nothing", 64'(out_valid), 64'd0);
      return;
    end
    if (intrude) begin
      for (int k = 0; k < 3; k++) begin
        in_valid = 1'b1;
        in_active = '1;
        for (int i = 0; i < LANES; i++) in_addr[i*AW +: AW] = 32'h00F0_0000 + AW'(i * 512);
        check(in_ready == 1'b0, "R10", "ready while busy", 64'(in_ready), 64'd0);
        @(negedge clk);
      end
      in_valid = 1'b0;
      ready_mode = 2;
    end
    while (!done) @(negedge clk);
    check(expq.size() == 0, "R4", "lanes left unserved at done", 64'(expq.size()), 64'd0);
    check(cyc == last_hs, "R12", "done cycle after last handshake", 64'(cyc), 64'(last_hs));
    @(negedge clk);
    check(done == 1'b0, "R12", "done is a single pulse", 64'(done), 64'd0);
  endtask

  task automatic fill(input logic [LANES-1:0] act, input logic [1:0] sz);
    b_act = act;
    b_sz = sz;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
    check(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);

    // R7 contiguous aligned
    fill('1, 2'd0);
    for (int i = 0; i < LANES; i++) b_addr[i] = 32'h1000 + AW'(4 * i);
    run_batch(1'b0);
    check(txn_cnt == 1, "R7", "one transaction", 64'(txn_cnt), 64'd1);
    check(last_base == 32'h1000 && last_size == 2'd1, "R7", "64B at base",
          64'({last_base, last_size}), 64'({32'h1000, 2'd1}));

    // R8 straddling 128-byte boundary
    for (int i = 0; i < LANES; i++) b_addr[i] = 32'h1074 + AW'(4 * i);
    run_batch(1'b0);
    check(txn_cnt == 2, "R8", "two transactions", 64'(txn_cnt), 64'd2);
    check(last_base == 32'h1080 && last_size == 2'd1, "R8", "second is 64B",
          64'({last_base, last_size}), 64'({32'h1080, 2'd1}));

    // R6 permuted lanes, then shrink to 32B
    for (int i = 0; i < LANES; i++) b_addr[i] = 32'h2000 + AW'(4 * ((i * 5) % 16));
    run_batch(1'b0);
    check(txn_cnt == 1 && last_size == 2'd1, "R6", "permuted 64B",
          64'({txn_cnt[7:0], last_size}), 64'({8'd1, 2'd1}));
    fill(16'h00FF, 2'd0);
    for (int i = 0; i < LANES; i++) b_addr[i] = (i < 8) ? 32'h2020 + AW'(4 * (7 - i)) : 32'h9000;
    run_batch(1'b0);
    check(last_base == 32'h2020 && last_size == 2'd0, "R6", "shrunk to 32B",
          64'({last_base, last_size}), 64'({32'h2020, 2'd0}));

    // R2 sparse and empty
    fill(16'h8001, 2'd0);
    for (int i = 0; i < LANES; i++) b_addr[i] = 32'h9000 + AW'(256 * i);
    b_addr[0] = 32'h3000; b_addr[15] = 32'h3004;
    run_batch(1'b0);
    check(txn_cnt == 1, "R2", "inactive lanes ignored", 64'(txn_cnt), 64'd1);
    fill('0, 2'd0);
    run_batch(1'b0);

    // R9 wider accesses
    fill(16'h0001, 2'd1);
    b_addr[0] = 32'h5000 + 28;
    run_batch(1'b0);
    check(last_base == 32'h5000 && last_size == 2'd1, "R9", "8B span crosses 32B",
          64'({last_base, last_size}), 64'({32'h5000, 2'd1}));
    fill(16'h0001, 2'd2);
    b_addr[0] = 32'h5070;
    run_batch(1'b0);
    check(last_base == 32'h5060 && last_size == 2'd0, "R9", "16B in top 32B",
          64'({last_base, last_size}), 64'({32'h5060, 2'd0}));
    fill('1, 2'd1);
    for (int i = 0; i < LANES; i++) b_addr[i] = 32'h6000 + AW'(8 * i);
    run_batch(1'b0);
    check(txn_cnt == 1 && last_size == 2'd2, "R9", "8B x16 gives 128B",
          64'({txn_cnt[7:0], last_size}), 64'({8'd1, 2'd2}));

    // R5 leader order
    fill(16'h0007, 2'd0);
    b_addr[0] = 32'h7080; b_addr[1] = 32'h7000; b_addr[2] = 32'h7090;
    run_batch(1'b0);
    check(txn_cnt == 2 && last_base == 32'h7000, "R5", "second round leads lane 1",
          64'(last_base), 64'h7000);

    // R10 input while busy, R11 stalls
    fill('1, 2'd0);
    for (int i = 0; i < LANES; i++) b_addr[i] = 32'h8000 + AW'(64 * i);
    run_batch(1'b1);

    ready_mode = 2;
    for (int n = 0; n < 40; n++) begin
      int bytes, off;
      logic [1:0] sz;
      sz = 2'($urandom % 4);
      bytes = (sz == 0) ? 4 : (sz == 1) ? 8 : 16;
      fill(16'($urandom), sz);
      for (int i = 0; i < LANES; i++) begin
        off = int'($urandom % 128);
        if (off + bytes > 128) off = 128 - bytes;
        b_addr[i] = 32'hA000 + AW'(128 * ($urandom % 3)) + AW'(off);
      end
      run_batch(1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule